// File: doc/BRIEF.md
# Prescaled Wrap Timer with Test-and-Skip Flag

This block is the interval timer of a small microcontroller core. An 8-bit up-counter advances once for every fixed number of instruction-cycle ticks. When it rolls over from its top value back to zero, two things happen at once. A sticky overflow flag is raised, and the core is released from its low-power idle state.

The core uses the flag with a test-and-skip instruction, which it signals by pulsing a test strobe. If the flag is set, the block clears the flag and raises a one-cycle skip request, so the core drops the following instruction. If the flag is clear, nothing happens. A separate strobe puts the core into idle, and idle lasts until the next rollover.

Top module: `tmr_ovf_skip`

## Requirements
- R1: While reset is high and in the first cycle after it, the count is 0x00, the overflow flag is 1, idle is 0 and the skip request is 0.
- R2: The count increases by exactly one on the clock edge that samples the 4th, 8th, 12th, ... asserted `cyc_tick`. Clock edges with `cyc_tick` low, and the other ticks, leave the count unchanged.
- R3: The count is 8 bits wide. The 1024th tick after reset moves it from 0xFF to 0x00.
- R4: The edge on which the count moves from 0xFF to 0x00 (a rollover) sets the overflow flag.
- R5: A rollover clears the idle flag.
- R6: A test strobe sampled while the flag is 1 clears the flag and makes `skip_req` 1 for the following cycle only.
- R7: A test strobe sampled while the flag is 0 leaves `skip_req` at 0 and the flag at 0.
- R8: An idle strobe sets the idle flag. The idle flag stays 1 until a rollover.
- R9: If a test strobe and a rollover fall on the same edge, the flag is 1 afterwards. `skip_req` is 1 only if the flag was 1 before that edge.
- R10: If an idle strobe and a rollover fall on the same edge, the idle flag is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_tick | input | 1 | One-cycle pulse per instruction cycle |
| test_req | input | 1 | Test-and-skip instruction strobe |
| idle_req | input | 1 | Enter-idle strobe |
| count | output | 8 | Current timer value |
| ovf_flag | output | 1 | Sticky rollover flag |
| idle | output | 1 | Core held in idle |
| skip_req | output | 1 | Request to skip the next instruction, one cycle wide |

## Verification
A wrong prescaler phase shows up as a count step one to three ticks away from a multiple of four. That is visible within the first four ticks, and it also shifts the rollover away from tick 1024. A flag or idle register that loses a same-edge conflict is visible at the port the cycle after that edge, and stays visible until the next test or rollover. A skip request derived from the flag's new value instead of its old one shows as a missing or extra pulse one cycle after the strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_WIDTH   = 8;
    localparam int TMR_PREDIV  = 4;

    // Flag state carried between the flag logic and the outputs
    typedef struct packed {
        logic ovf;
        logic idle;
        logic skip;
    } tmr_flags_t;

    localparam tmr_flags_t TMR_FLAGS_RST = '{ovf: 1'b1, idle: 1'b0, skip: 1'b0};

    // True when a counter of the given value sits at its all-ones top
    function automatic logic at_top(input logic [31:0] val, input int width);
        logic [31:0] top;
        top = (32'd1 << width) - 32'd1;
        return (val & top) == top;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_tick,
    output logic adv
);
    generate
        if (DIV <= 1) begin : g_direct
            assign adv = cyc_tick;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase;

            assign adv = cyc_tick && (phase == LAST);

            always_ff @(posedge clk) begin
                if (rst) begin
                    phase <= '0;
                end else if (cyc_tick) begin
                    phase <= (phase == LAST) ? '0 : phase + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] count,
    output logic         wrap
);
    import tmr_pkg::*;

    assign wrap = adv && at_top(32'(count), W);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (adv) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap,
    input  logic              test_req,
    input  logic              idle_req,
    output tmr_pkg::tmr_flags_t st
);
    import tmr_pkg::*;

    tmr_flags_t nxt;

    always_comb begin
        nxt      = st;
        // skip follows the flag value seen by the test, not the updated one
        nxt.skip = test_req && st.ovf;
        if (wrap)               nxt.ovf = 1'b1;
        else if (test_req)      nxt.ovf = 1'b0;
        if (wrap)               nxt.idle = 1'b0;
        else if (idle_req)      nxt.idle = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= TMR_FLAGS_RST;
        else     st <= nxt;
    end
endmodule

// File: rtl/tmr_ovf_skip.sv
module tmr_ovf_skip #(
    parameter int WIDTH  = tmr_pkg::TMR_WIDTH,
    parameter int PREDIV = tmr_pkg::TMR_PREDIV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_tick,
    input  logic             test_req,
    input  logic             idle_req,
    output logic [WIDTH-1:0] count,
    output logic             ovf_flag,
    output logic             idle,
    output logic             skip_req
);
    import tmr_pkg::*;

    logic       adv;
    logic       wrap;
    tmr_flags_t st;

    tmr_prescale #(.DIV(PREDIV)) u_pre (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .adv(adv)
    );

    tmr_count #(.W(WIDTH)) u_cnt (
        .clk(clk), .rst(rst), .adv(adv), .count(count), .wrap(wrap)
    );

    tmr_flags u_flg (
        .clk(clk), .rst(rst), .wrap(wrap),
        .test_req(test_req), .idle_req(idle_req), .st(st)
    );

    assign ovf_flag = st.ovf;
    assign idle     = st.idle;
    assign skip_req = st.skip;
endmodule

// File: rtl/tmr_ovf_skip_chk.sv
module tmr_ovf_skip_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             test_req,
    input logic             idle_req,
    input logic [WIDTH-1:0] count,
    input logic             ovf_flag,
    input logic             idle,
    input logic             skip_req
);
    localparam logic [WIDTH-1:0] TOP = '1;

    // R2: the count only ever moves up by one
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == $past(count) + 1'b1));

    // R4, R5: a rollover leaves the flag set and idle released
    a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && $past(count) == TOP) |-> (ovf_flag && !idle));

    // R4: the flag rises only on a rollover
    a_r4_flag_rise_on_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> (count == '0 && $past(count) == TOP));

    // R6: a skip pulse needs a test that saw the flag set
    a_r6_skip_cause: assert property (@(posedge clk) disable iff (rst)
        skip_req |-> ($past(test_req) && $past(ovf_flag)));

    // R6: a test without a rollover leaves the flag clear
    a_r6_test_clears: assert property (@(posedge clk) disable iff (rst)
        ($past(test_req) && !(count == '0 && $past(count) == TOP)) |-> !ovf_flag);

    // R8: idle rises only after an idle strobe
    a_r8_idle_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(idle) |-> $past(idle_req));
endmodule

bind tmr_ovf_skip tmr_ovf_skip_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .test_req(test_req), .idle_req(idle_req),
    .count(count), .ovf_flag(ovf_flag), .idle(idle), .skip_req(skip_req)
);

// File: tb/tmr_ovf_skip_test.sv
`timescale 1ns/1ps
module tmr_ovf_skip_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_tick = 1'b0;
    logic       test_req = 1'b0;
    logic       idle_req = 1'b0;
    logic [7:0] count;
    logic       ovf_flag, idle, skip_req;

    int checks = 0;
    int failures = 0;
    int ticks = 0;
    logic e_ovf = 1'b1, e_idle = 1'b0;

    always #2 clk = ~clk;

    tmr_ovf_skip uut (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .test_req(test_req),
        .idle_req(idle_req), .count(count), .ovf_flag(ovf_flag),
        .idle(idle), .skip_req(skip_req)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock with the given strobes; expected values from the requirements
    task automatic step(input logic tk, input logic ts, input logic id);
        logic wr, e_skip;
        string lt, it;
        wr = tk && ((ticks + 1) % 1024 == 0);
        e_skip = ts && e_ovf;
        if (wr && ts) lt = "R9";
        else if (wr) lt = "R4";
        else if (ts && !e_ovf) lt = "R7";
        else lt = "R6";
        if (wr && id) it = "R10";
        else if (wr) it = "R5";
        else it = "R8";
        if (wr) e_ovf = 1'b1; else if (ts) e_ovf = 1'b0;
        if (wr) e_idle = 1'b0; else if (id) e_idle = 1'b1;
        if (tk) ticks++;
        cyc_tick = tk; test_req = ts; idle_req = id;
        @(posedge clk); #1;
        cyc_tick = 1'b0; test_req = 1'b0; idle_req = 1'b0;
        chk(count == 8'((ticks / 4) % 256), wr ? "R3 count" : "R2 count",
            count, (ticks / 4) % 256);
        chk(ovf_flag == e_ovf, lt, ovf_flag, e_ovf);
        chk(idle == e_idle, it, idle, e_idle);
        chk(skip_req == e_skip, (ts && !e_skip) ? "R7 skip" : "R6 skip",
            skip_req, e_skip);
    endtask

    // run ticks with an irregular gap pattern until the total reaches target
    task automatic run_to(input int target);
        for (int i = 0; ticks < target; i++) begin
            step((i % 3) != 1, 1'b0, 1'b0);
        end
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: values held during reset
        chk(count == 8'h00, "R1 count", count, 0);
        chk(ovf_flag == 1'b1, "R1 flag", ovf_flag, 1);
        chk(idle == 1'b0, "R1 idle", idle, 0);
        chk(skip_req == 1'b0, "R1 skip", skip_req, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(count == 8'h00 && ovf_flag && !idle && !skip_req, "R1 post", count, 0);

        step(1'b0, 1'b1, 1'b0);   // R6: flag set at reset, test consumes it
        step(1'b0, 1'b0, 1'b0);   // R6: pulse is one cycle
        step(1'b0, 1'b1, 1'b0);   // R7: flag now clear
        step(1'b0, 1'b0, 1'b1);   // R8: enter idle
        run_to(1024);             // R2, R3 full lap; R4, R5 at rollover
        step(1'b0, 1'b1, 1'b0);   // R6: consume the new flag
        run_to(2047);
        step(1'b1, 1'b1, 1'b1);   // R9, R10 with flag clear beforehand
        run_to(3071);
        step(1'b1, 1'b1, 1'b0);   // R9 with flag set beforehand: skip and stays set
        step(1'b0, 1'b1, 1'b0);   // R6: now cleared
        for (int k = 0; k < 12; k++) step(1'b1, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule